// File: doc/BRIEF.md
# Single-Word Bus-Master DMA Request Controller

This block lets a peripheral card become bus master for short DMA cycles. Each cycle moves exactly one 16-bit word between the host bus and the card's local data port. Firmware programs a word count, a direction, an arbitration level and a re-request mode, then pulses a start strobe. For every word the controller raises a request toward the bus arbiter and drives its level during the arbitration period. It backs off when a more urgent contender appears. When it has won, it drops the request at the first clock of the grant period, so the arbitration bus is free before the host's command strobe even begins.

The busy indication that firmware polls is separate from the bus request. It stays set until the command strobe of the final word has ended, so a clear busy bit always means the data has moved. The burst output is tied inactive, which keeps the system DMA controller in single-transfer operation. Two re-request modes are offered. In the baseline mode the next word is requested only after the DMA cycle has fully ended, marked by the next arbitration period. In the early mode it is requested as soon as the current word's strobe ends.

All bus inputs are assumed to be already synchronised to `clk`. Every output is decoded from registered state, so no output is built from unregistered logic that mixes the two clock domains.

Top module: `dma_single_req`

## Requirements
- R1: After reset, `bus_req`, `arb_oe`, `bus_doe`, `dp_pop`, `dp_push`, `req_busy` and `req_done` are 0, `arb_out` is 0 and `req_phase` is 0 (idle).
- R2: `burst_req` is 0 in every cycle, including reset, arbitration and data transfer.
- R3: A `fw_start` pulse with a non-zero `cfg_count` in the idle state sets `req_busy` and `bus_req` at the next clock edge, with `req_phase` = 1 (requesting). A start with `cfg_count` = 0 is ignored, and the block stays idle.
- R4: While requesting, a sampled `arb_phase` = 1 moves the block to arbitration at the next edge. There `arb_oe` = 1, `arb_out` = the latched level and `req_phase` = 2. If `arb_in` is numerically lower than the level (lower value = higher priority) while `arb_phase` = 1, `arb_oe` drops at the next edge and `bus_req` stays 1.
- R5: At the first edge where `arb_phase` = 0 and `arb_in` equals the driven level, `bus_req` and `arb_oe` drop and `req_phase` becomes 3. The command strobe is not needed for this. If `arb_in` differs, the block returns to requesting and `bus_req` stays 1.
- R6: `req_busy` stays 1 from start until the edge at which `cmd` is sampled 0 after the last word's strobe. At that edge `req_busy` clears and `req_done` sets. Winning arbitration alone never clears it.
- R7: When a word that is not the last completes, early mode (`cfg_early` = 1) raises `bus_req` at that same edge. Baseline mode keeps `bus_req` at 0 until `arb_phase` = 1 is sampled and raises it at that edge.
- R8: Card-to-host (`cfg_dir` = 0): `dp_rdata` is captured at the winning edge and `dp_pop` is 1 for the following cycle. From the edge where `cmd` and `dma_sel` are both sampled 1, `bus_doe` = 1 and `bus_dout` equals the captured word, until `cmd` is sampled 0.
- R9: Host-to-card (`cfg_dir` = 1): at the edge where `cmd` and `dma_sel` are sampled 1, `bus_din` is captured onto `dp_wdata` and `dp_push` is 1 for one cycle. `bus_doe` stays 0.
- R10: `fw_abort` returns the block to idle at the next edge from any state. It clears `req_busy` and `req_done` and drops `bus_req`, `arb_oe` and `bus_doe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_level | input | 4 | Arbitration level, latched at start |
| cfg_dir | input | 1 | 0 = card to host, 1 = host to card, latched at start |
| cfg_early | input | 1 | 1 = re-request as soon as a word ends |
| cfg_count | input | 8 | Number of words to move, latched at start |
| fw_start | input | 1 | Start pulse from firmware |
| fw_abort | input | 1 | Abort pulse from firmware |
| req_busy | output | 1 | Words still outstanding |
| req_done | output | 1 | Last word has moved (sticky) |
| req_phase | output | 2 | 0 idle, 1 requesting, 2 arbitrating, 3 selected |
| arb_phase | input | 1 | 1 = arbitration period, 0 = grant period |
| arb_in | input | 4 | Resolved arbitration bus value |
| arb_out | output | 4 | Level driven onto the arbitration bus |
| arb_oe | output | 1 | Drive enable for `arb_out` |
| bus_req | output | 1 | Request toward the arbiter |
| burst_req | output | 1 | Burst control, always inactive |
| dma_sel | input | 1 | Card selected for the current DMA cycle |
| cmd | input | 1 | Command strobe, active high |
| bus_din | input | 16 | Host data for host-to-card words |
| bus_dout | output | 16 | Card data for card-to-host words |
| bus_doe | output | 1 | Drive enable for `bus_dout` |
| dp_rdata | input | 16 | Next word from the card data port |
| dp_pop | output | 1 | Card data port advance |
| dp_wdata | output | 16 | Word written to the card data port |
| dp_push | output | 1 | Card data port write strobe |

## Verification
Two events can land on the same edge. One is the end of a word's strobe, which decrements the outstanding count. The other is the raising of the next request, which in early mode happens on that very edge. The bench runs two-word host-to-card transfers in both modes. At the edge where `cmd` returns to 0 it checks that busy is still set, and that `bus_req` is 1 in early mode and 0 in baseline mode. It then checks whether the next arbitration period finds the block already arbitrating or only just requesting. A second sweep covers every pair of own level and competing level. It confirms that the request is released at the first grant clock, before any strobe, while busy stays set until the strobe ends.

// File: rtl/dma_req_pkg.sv
// Package: shared state encoding and status phase codes for the DMA request
// controller. Assumes nothing beyond IEEE 1800-2017 enums.
package dma_req_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,   // nothing outstanding
        S_REQ  = 3'd1,   // request raised, waiting for an arbitration period
        S_ARB  = 3'd2,   // driving the level during arbitration
        S_WAIT = 3'd3,   // outranked, waiting for the period to end
        S_OWN  = 3'd4,   // won, request released, waiting for the strobe
        S_XFER = 3'd5,   // strobe active, word moving
        S_GAP  = 3'd6    // baseline mode: waiting for the cycle to end
    } req_state_t;

    localparam logic [1:0] PH_IDLE = 2'd0;
    localparam logic [1:0] PH_REQ  = 2'd1;
    localparam logic [1:0] PH_ARB  = 2'd2;
    localparam logic [1:0] PH_SEL  = 2'd3;

endpackage

// File: rtl/dma_arb_cmp.sv
// Module: priority comparator for the arbitration bus.
// Compares the resolved bus value with the card's own level, MSB first.
// A lower numeric value has higher priority. Purely combinational.
module dma_arb_cmp #(
    parameter int LW = 4
) (
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] bus_val,
    output logic          outranked,
    output logic          matched
);

    logic [LW:0]   eq_chain;
    logic [LW-1:0] lt_bit;

    assign eq_chain[LW] = 1'b1;

    // Per-bit ripple: equality of all higher bits, and a lower bus bit here.
    for (genvar i = LW - 1; i >= 0; i--) begin : g_bit
        assign eq_chain[i] = eq_chain[i+1] & (level[i] == bus_val[i]);
        assign lt_bit[i]   = eq_chain[i+1] & level[i] & ~bus_val[i];
    end

    assign outranked = |lt_bit;
    assign matched   = eq_chain[0];

endmodule

// File: rtl/dma_word_count.sv
// Module: outstanding-word counter.
// Loaded at start, decremented when a word's strobe ends, cleared on abort.
// Assumes a decrement never arrives while the count is zero.
module dma_word_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    input  logic          clear,
    output logic [CW-1:0] remaining,
    output logic          is_last,
    output logic          is_busy
);

    localparam logic [CW-1:0] ONE = CW'(1);

    // Count register: clear has priority, then load, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec && remaining != '0) begin
            remaining <= remaining - ONE;
        end
    end

    assign is_last = (remaining == ONE);
    assign is_busy = (remaining != '0);

endmodule

// File: rtl/dma_word_path.sv
// Module: single-word holding register between host bus and card port.
// One register serves both directions: it is loaded from the card port when
// arbitration is won (card to host) or from the host bus when the strobe
// starts (host to card). Pop and push are one-cycle registered pulses.
module dma_word_path #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_rd,
    input  logic [DW-1:0] dp_rdata,
    input  logic          cap_wr,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] hold_q,
    output logic          dp_pop,
    output logic          dp_push
);

    // Holding register: takes whichever side supplies the word this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load_rd) begin
            hold_q <= dp_rdata;
        end else if (cap_wr) begin
            hold_q <= bus_din;
        end
    end

    // Port strobes: one cycle after the capture that caused them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_pop  <= 1'b0;
            dp_push <= 1'b0;
        end else begin
            dp_pop  <= load_rd;
            dp_push <= cap_wr;
        end
    end

endmodule

// File: rtl/dma_single_req.sv
// Module: single-word bus-master DMA request controller (top).
// Raises a request per word, arbitrates with a latched level, releases the
// request at the first grant clock after winning, and keeps the firmware
// busy bit set until the word's strobe has ended. Bus inputs are assumed to
// be synchronous to clk. Outputs are decoded from registered state only.
module dma_single_req
    import dma_req_pkg::*;
#(
    parameter int DW = 16,
    parameter int LW = 4,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cfg_level,
    input  logic          cfg_dir,
    input  logic          cfg_early,
    input  logic [CW-1:0] cfg_count,
    input  logic          fw_start,
    input  logic          fw_abort,
    output logic          req_busy,
    output logic          req_done,
    output logic [1:0]    req_phase,
    input  logic          arb_phase,
    input  logic [LW-1:0] arb_in,
    output logic [LW-1:0] arb_out,
    output logic          arb_oe,
    output logic          bus_req,
    output logic          burst_req,
    input  logic          dma_sel,
    input  logic          cmd,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic [DW-1:0] dp_rdata,
    output logic          dp_pop,
    output logic [DW-1:0] dp_wdata,
    output logic          dp_push
);

    req_state_t    state_q, state_d;
    logic [LW-1:0] level_q;
    logic          dir_q;
    logic          early_q;
    logic          done_q;
    logic          outranked, matched;
    logic          cnt_last, cnt_busy;
    logic [CW-1:0] cnt_remaining;
    logic [DW-1:0] hold_q;
    logic          start_ok, win, sel_hit, word_end;

    // Event decode from registered state and sampled inputs.
    assign start_ok = fw_start && !fw_abort && (state_q == S_IDLE) && (cfg_count != '0);
    assign win      = (state_q == S_ARB) && !arb_phase && matched;
    assign sel_hit  = (state_q == S_OWN) && cmd && dma_sel;
    assign word_end = (state_q == S_XFER) && !cmd;

    dma_arb_cmp #(.LW(LW)) u_cmp (
        .level     (level_q),
        .bus_val   (arb_in),
        .outranked (outranked),
        .matched   (matched)
    );

    dma_word_count #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_ok),
        .load_val  (cfg_count),
        .dec       (word_end),
        .clear     (fw_abort),
        .remaining (cnt_remaining),
        .is_last   (cnt_last),
        .is_busy   (cnt_busy)
    );

    dma_word_path #(.DW(DW)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_rd  (win && !dir_q),
        .dp_rdata (dp_rdata),
        .cap_wr   (sel_hit && dir_q),
        .bus_din  (bus_din),
        .hold_q   (hold_q),
        .dp_pop   (dp_pop),
        .dp_push  (dp_push)
    );

    // Configuration latch: captured once per accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            dir_q   <= 1'b0;
            early_q <= 1'b0;
        end else if (start_ok) begin
            level_q <= cfg_level;
            dir_q   <= cfg_dir;
            early_q <= cfg_early;
        end
    end

    // Next-state logic for the per-word request sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_ok) state_d = S_REQ;
            S_REQ:  if (arb_phase) state_d = S_ARB;
            S_ARB: begin
                if (!arb_phase)     state_d = matched ? S_OWN : S_REQ;
                else if (outranked) state_d = S_WAIT;
            end
            S_WAIT: if (!arb_phase) state_d = S_REQ;
            S_OWN:  if (cmd && dma_sel) state_d = S_XFER;
            S_XFER: begin
                if (!cmd) begin
                    if (cnt_last)     state_d = S_IDLE;
                    else if (early_q) state_d = S_REQ;
                    else              state_d = S_GAP;
                end
            end
            S_GAP:  if (arb_phase) state_d = S_REQ;
            default: state_d = S_IDLE;
        endcase
        if (fw_abort) state_d = S_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Sticky completion flag: set by the last word, cleared by start or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || fw_abort || start_ok) done_q <= 1'b0;
        else if (word_end && cnt_last)      done_q <= 1'b1;
    end

    // Output decode from registered state.
    always_comb begin
        bus_req = (state_q == S_REQ) || (state_q == S_ARB) || (state_q == S_WAIT);
        arb_oe  = (state_q == S_ARB);
        arb_out = arb_oe ? level_q : '0;
        bus_doe = (state_q == S_XFER) && !dir_q;
        unique case (state_q)
            S_IDLE:                req_phase = PH_IDLE;
            S_ARB:                 req_phase = PH_ARB;
            S_OWN, S_XFER:         req_phase = PH_SEL;
            default:               req_phase = PH_REQ;
        endcase
    end

    assign burst_req = 1'b0;
    assign bus_dout  = hold_q;
    assign dp_wdata  = hold_q;
    assign req_busy  = cnt_busy;
    assign req_done  = done_q;

endmodule

// File: rtl/dma_single_req_chk.sv
// Checker: temporal properties of the request controller, bound to the top.
module dma_single_req_chk #(
    parameter int LW = 4,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fw_start,
    input logic          fw_abort,
    input logic          arb_phase,
    input logic [LW-1:0] arb_in,
    input logic [LW-1:0] arb_out,
    input logic          arb_oe,
    input logic          bus_req,
    input logic          cmd,
    input logic          bus_doe,
    input logic          dp_pop,
    input logic          dp_push,
    input logic          req_busy,
    input logic [CW-1:0] remaining
);

    // R5: the request only falls in a grant period or on abort.
    assert_fall_in_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> ($past(fw_abort) || !$past(arb_phase)));

    // R5: a won grant releases the request at the next edge.
    assert_release_after_win_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_oe && !arb_phase && arb_in == arb_out) |=> !bus_req);

    // R4: an outranked contender stops driving its level.
    assert_withdraw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_oe && arb_phase && arb_in < arb_out) |=> !arb_oe);

    // R4: the level is only driven while requesting.
    assert_drive_with_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_oe |-> bus_req);

    // R6: busy clears only after a strobe ends, or on abort.
    assert_busy_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_busy) |-> ($past(fw_abort) || ($past(cmd, 2) && !$past(cmd))));

    // R6: the outstanding count only steps down by one unless reloaded or aborted.
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining != $past(remaining)) |->
            (remaining == $past(remaining) - CW'(1)) || $past(fw_start) || $past(fw_abort));

    // R8: the data drive follows an active strobe.
    assert_drive_in_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> $past(cmd));

    // R9: the card port is never read and written in one cycle.
    assert_single_port_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_pop && dp_push));

endmodule

bind dma_single_req dma_single_req_chk #(.LW(LW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fw_start  (fw_start),
    .fw_abort  (fw_abort),
    .arb_phase (arb_phase),
    .arb_in    (arb_in),
    .arb_out   (arb_out),
    .arb_oe    (arb_oe),
    .bus_req   (bus_req),
    .cmd       (cmd),
    .bus_doe   (bus_doe),
    .dp_pop    (dp_pop),
    .dp_push   (dp_push),
    .req_busy  (req_busy),
    .remaining (cnt_remaining)
);

// File: tb/tb_dma_single_req.sv
// Bench: sweeps every own/competing level pair, both directions and both
// re-request modes; expected values come from the requirements.
module tb_dma_single_req;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_level = '0;
    logic        cfg_dir = 1'b0;
    logic        cfg_early = 1'b0;
    logic [7:0]  cfg_count = '0;
    logic        fw_start = 1'b0;
    logic        fw_abort = 1'b0;
    logic        req_busy, req_done;
    logic [1:0]  req_phase;
    logic        arb_phase = 1'b0;
    logic [3:0]  arb_in = 4'hF;
    logic [3:0]  arb_out;
    logic        arb_oe, bus_req, burst_req;
    logic        dma_sel = 1'b0;
    logic        cmd = 1'b0;
    logic [15:0] bus_din = '0;
    logic [15:0] bus_dout;
    logic        bus_doe;
    logic [15:0] dp_rdata = '0;
    logic        dp_pop;
    logic [15:0] dp_wdata;
    logic        dp_push;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dma_single_req dut (
        .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_dir(cfg_dir),
        .cfg_early(cfg_early), .cfg_count(cfg_count), .fw_start(fw_start),
        .fw_abort(fw_abort), .req_busy(req_busy), .req_done(req_done),
        .req_phase(req_phase), .arb_phase(arb_phase), .arb_in(arb_in),
        .arb_out(arb_out), .arb_oe(arb_oe), .bus_req(bus_req),
        .burst_req(burst_req), .dma_sel(dma_sel), .cmd(cmd), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .dp_rdata(dp_rdata),
        .dp_pop(dp_pop), .dp_wdata(dp_wdata), .dp_push(dp_push)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: inputs were set between edges, outputs sampled 1 ns after.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic start(input logic [3:0] lvl, input logic dir, input logic early,
                         input logic [7:0] cnt);
        cfg_level = lvl; cfg_dir = dir; cfg_early = early; cfg_count = cnt;
        fw_start = 1'b1;
        step();
        fw_start = 1'b0;
    endtask

    // Two-word host-to-card run, checking the re-request timing.
    task automatic mode_run(input logic early);
        start(4'd3, 1'b1, early, 8'd2);
        arb_phase = 1'b1; arb_in = 4'd3; step();
        arb_phase = 1'b0; step();
        chk("R5 released before strobe", 32'(bus_req), 32'd0);
        bus_din = 16'hC0DE ^ 16'(early); cmd = 1'b1; dma_sel = 1'b1; step();
        chk("R9 push strobe", 32'(dp_push), 32'd1);
        chk("R9 captured word", 32'(dp_wdata), 32'(16'hC0DE ^ 16'(early)));
        chk("R9 no data drive", 32'(bus_doe), 32'd0);
        cmd = 1'b0; dma_sel = 1'b0; step();
        chk("R6 busy after first word", 32'(req_busy), 32'd1);
        chk("R7 request at word end", 32'(bus_req), 32'(early));
        step();
        chk("R7 request held in grant", 32'(bus_req), 32'(early));
        arb_phase = 1'b1; step();
        chk("R7 arbitrating at next period", 32'(arb_oe), 32'(early));
        chk("R7 request at next period", 32'(bus_req), 32'd1);
        if (!early) step();
        arb_phase = 1'b0; step();
        cmd = 1'b1; dma_sel = 1'b1; bus_din = 16'h1234; step();
        chk("R9 second word", 32'(dp_wdata), 32'h1234);
        cmd = 1'b0; dma_sel = 1'b0; step();
        chk("R6 busy clear at end", 32'(req_busy), 32'd0);
        chk("R6 done set", 32'(req_done), 32'd1);
        chk("R7 no request after last", 32'(bus_req), 32'd0);
        arb_in = 4'hF;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) step();
        chk("R1 bus_req", 32'(bus_req), 32'd0);
        chk("R1 arb_oe", 32'(arb_oe), 32'd0);
        chk("R1 busy", 32'(req_busy), 32'd0);
        chk("R1 phase", 32'(req_phase), 32'd0);
        chk("R2 burst in reset", 32'(burst_req), 32'd0);
        rst_n = 1'b1;
        step();
        chk("R1 outputs idle", 32'({bus_doe, dp_pop, dp_push, req_done, arb_out}), 32'd0);

        start(4'd5, 1'b0, 1'b0, 8'd0);
        chk("R3 zero count ignored", 32'({req_busy, bus_req, req_phase}), 32'd0);

        for (int lvl = 0; lvl < 16; lvl++) begin
            for (int comp = 0; comp < 16; comp++) begin
                logic won;
                logic [15:0] word;
                won  = (comp >= lvl);
                word = {4'(lvl), 4'(comp), 8'hA5};
                dp_rdata = word;
                start(4'(lvl), 1'b0, 1'b0, 8'd1);
                chk("R3 busy", 32'(req_busy), 32'd1);
                chk("R3 request", 32'(bus_req), 32'd1);
                chk("R3 phase", 32'(req_phase), 32'd1);
                arb_phase = 1'b1; arb_in = 4'(lvl); step();
                chk("R4 drive level", 32'({arb_oe, arb_out}), 32'({1'b1, 4'(lvl)}));
                chk("R4 phase", 32'(req_phase), 32'd2);
                arb_in = won ? 4'(lvl) : 4'(comp); step();
                chk("R4 withdraw", 32'(arb_oe), 32'(won));
                chk("R4 request kept", 32'(bus_req), 32'd1);
                chk("R2 burst", 32'(burst_req), 32'd0);
                arb_phase = 1'b0; step();
                chk("R5 request after grant", 32'(bus_req), 32'(!won));
                chk("R5 phase", 32'(req_phase), won ? 32'd3 : 32'd1);
                if (won) begin
                    chk("R8 pop", 32'(dp_pop), 32'd1);
                    step();
                    chk("R6 busy held until strobe", 32'(req_busy), 32'd1);
                    cmd = 1'b1; dma_sel = 1'b1; step();
                    chk("R8 drive", 32'(bus_doe), 32'd1);
                    chk("R8 word", 32'(bus_dout), 32'(word));
                    chk("R2 burst in transfer", 32'(burst_req), 32'd0);
                    cmd = 1'b0; dma_sel = 1'b0; step();
                    chk("R6 busy cleared", 32'(req_busy), 32'd0);
                    chk("R6 done", 32'(req_done), 32'd1);
                    chk("R8 drive off", 32'(bus_doe), 32'd0);
                end else begin
                    fw_abort = 1'b1; step(); fw_abort = 1'b0;
                    chk("R10 abort idle", 32'({req_busy, bus_req, arb_oe, req_phase}), 32'd0);
                end
                arb_in = 4'hF;
            end
        end

        mode_run(1'b0);
        mode_run(1'b1);

        // Abort while selected: everything released, done cleared.
        start(4'd2, 1'b0, 1'b0, 8'd3);
        arb_phase = 1'b1; arb_in = 4'd2; step();
        arb_phase = 1'b0; step();
        cmd = 1'b1; dma_sel = 1'b1; step();
        chk("R10 pre-abort drive", 32'(bus_doe), 32'd1);
        fw_abort = 1'b1; step(); fw_abort = 1'b0;
        cmd = 1'b0; dma_sel = 1'b0;
        chk("R10 abort releases", 32'({bus_doe, bus_req, arb_oe, req_busy, req_done}), 32'd0);
        chk("R10 abort phase", 32'(req_phase), 32'd0);
        step();
        chk("R10 stays idle", 32'({bus_req, req_phase}), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule